// File: doc/BRIEF.md
# Programmable Tick Timer

The block is a tick timer. A 32-bit up-counter runs from the always-on system clock. A comparator checks it every cycle against a 28-bit programmable match value. A small mode controller decides what the counter does on a match, and whether it counts at all. There are four modes: off, single-shot, restartable and continuous. All three counting modes share the one counter and the one comparator. In single-shot mode a match freezes the count. In restartable mode a match sends the count back to zero, which gives a fixed period. In continuous mode the counter runs on past the match and wraps around.

Every match sets a sticky event flag. Software clears the flag with a write-one-to-clear strobe. The interrupt output is this flag gated by an enable input. The current count is always visible on an output. A clear strobe returns the count to zero without a change of mode. Writing any new mode code also clears the count.

Top module: `tick_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `count_o` is 0, `irq_o` is 0 and the timer is in the off mode.
- R2: Mode code 0 (off) holds the counter at 0 and produces no match events. The other codes are 1 = single-shot, 2 = restartable and 3 = continuous.
- R3: At the clock edge where `mode_i` differs from the mode in force, the counter is cleared to 0 and that edge produces no match event. Counting in the new mode starts at the following edge.
- R4: A match event occurs at a clock edge where the running counter equals the 28-bit `match_i` value zero-extended to 32 bits.
- R5: In single-shot mode the counter stops at the match value and holds it. No further match events occur until a clear strobe or a mode change.
- R6: In restartable mode the counter goes from the match value to 0 and counts on. The period is match+1 cycles.
- R7: In continuous mode the counter keeps incrementing through the match value and wraps from all-ones to 0. A match event occurs once per pass.
- R8: A one-cycle `cnt_clr_i` strobe clears the counter to 0. It also re-arms a single-shot timer that has stopped. A mode change takes precedence over it.
- R9: A match event sets the sticky flag. The flag stays set until a cycle with `irq_clr_i` high and no match event. A match event in the same cycle as `irq_clr_i` leaves the flag set.
- R10: `irq_o` is the sticky flag ANDed with `irq_en_i`. Masking the interrupt does not clear the flag, so re-enabling shows a pending event at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Run mode: 0 off, 1 single-shot, 2 restartable, 3 continuous |
| match_i | input | MATCH_W (28) | Match value compared against the counter |
| cnt_clr_i | input | 1 | Strobe that clears the counter to zero |
| irq_en_i | input | 1 | Interrupt enable (mask) |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the sticky match flag |
| irq_o | output | 1 | Masked match interrupt |
| count_o | output | CNT_W (32) | Current counter value |

## Verification
The assertions check several rules on every cycle:
- a clear command empties the counter and an advance command increments it by exactly one;
- the counter holds in every other cycle;
- a match event only occurs when the count equals the extended match value;
- the sticky flag follows the set and clear rules;
- the halted state only exists in single-shot mode.

Some behaviour only the bench scenarios can show:
- the sequences that span many cycles, such as the restart period, the single-shot hold after a cleared interrupt, and the masked flag reappearing;
- wrap-around in continuous mode, shown on a second, narrow instance whose counter wraps within a few thousand cycles;
- the random mix of mode changes, clear strobes and masks, checked cycle by cycle against a behavioural model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Run-mode codes, as seen on the mode input
  typedef enum logic [1:0] {
    TM_OFF     = 2'd0,
    TM_ONESHOT = 2'd1,
    TM_RESTART = 2'd2,
    TM_FREE    = 2'd3
  } tick_mode_e;

  // Command from the mode controller to the counter
  typedef struct packed {
    logic clear;
    logic advance;
  } cnt_cmd_t;

endpackage

// File: rtl/tick_mode_ctl.sv
module tick_mode_ctl
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       cnt_clr_i,
  input  logic       hit_i,
  output tick_mode_e mode_q_o,
  output logic       mode_chg_o,
  output logic       halted_o,
  output logic       match_evt_o,
  output cnt_cmd_t   cmd_o
);

  tick_mode_e mode_q;
  tick_mode_e mode_req;
  logic       halted_q;
  logic       halted_d;
  logic       evt;
  logic       running;

  assign mode_req = tick_mode_e'(mode_i);
  assign mode_chg_o = (mode_req != mode_q);

  // Counting is gated here: off mode, a pending mode switch or a clear stop it
  assign running = (mode_q != TM_OFF) && !mode_chg_o && !cnt_clr_i;
  assign evt     = running && hit_i && !halted_q;

  always_comb begin
    cmd_o.clear   = mode_chg_o || cnt_clr_i || (mode_q == TM_OFF)
                  || (evt && (mode_q == TM_RESTART));
    cmd_o.advance = !cmd_o.clear && !halted_q
                  && !(evt && (mode_q == TM_ONESHOT));
  end

  always_comb begin
    halted_d = halted_q;
    if (mode_chg_o || cnt_clr_i) begin
      halted_d = 1'b0;
    end else if (evt && (mode_q == TM_ONESHOT)) begin
      halted_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= TM_OFF;
      halted_q <= 1'b0;
    end else begin
      mode_q   <= mode_req;
      halted_q <= halted_d;
    end
  end

  assign mode_q_o    = mode_q;
  assign halted_o    = halted_q;
  assign match_evt_o = evt;

  // R5
  halt_only_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> (mode_q == TM_ONESHOT));

  // R5
  halt_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> !match_evt_o);

  // R3
  switch_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o |-> !match_evt_o);

endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_cmd_t         cmd_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cmd_i.clear) begin
      count_q <= '0;
    end else if (cmd_i.advance) begin
      count_q <= bump(count_q);
    end
  end

  assign count_o = count_q;

  // R8
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.clear |=> (count_q == '0));

  // R7
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.advance && !cmd_i.clear) |=> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i.advance && !cmd_i.clear) |=> $stable(count_q));

endmodule

// File: rtl/tick_match_irq.sv
module tick_match_irq #(
  parameter int CNT_W   = 32,
  parameter int MATCH_W = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic               evt_i,
  input  logic               irq_en_i,
  input  logic               irq_clr_i,
  output logic               hit_o,
  output logic               flag_o,
  output logic               irq_o
);

  logic flag_q;

  function automatic logic [CNT_W-1:0] widen(input logic [MATCH_W-1:0] m);
    return CNT_W'(m);
  endfunction

  assign hit_o = (count_i == widen(match_i));

  // Set has priority over the write-one-to-clear strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (evt_i) begin
      flag_q <= 1'b1;
    end else if (irq_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);

  // R9
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && irq_clr_i) |=> !flag_q);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !irq_clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MATCH_W = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic [MATCH_W-1:0] match_i,
  input  logic               cnt_clr_i,
  input  logic               irq_en_i,
  input  logic               irq_clr_i,
  output logic               irq_o,
  output logic [CNT_W-1:0]   count_o
);

  tick_mode_e mode_q;
  logic       mode_chg;
  logic       halted;
  logic       match_evt;
  logic       hit;
  logic       flag;
  cnt_cmd_t   cmd;

  tick_mode_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cnt_clr_i  (cnt_clr_i),
    .hit_i      (hit),
    .mode_q_o   (mode_q),
    .mode_chg_o (mode_chg),
    .halted_o   (halted),
    .match_evt_o(match_evt),
    .cmd_o      (cmd)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd),
    .count_o(count_o)
  );

  tick_match_irq #(.CNT_W(CNT_W), .MATCH_W(MATCH_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_o),
    .match_i  (match_i),
    .evt_i    (match_evt),
    .irq_en_i (irq_en_i),
    .irq_clr_i(irq_clr_i),
    .hit_o    (hit),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  // R2
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TM_OFF) |-> (count_o == '0));

  // R3
  switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (count_o == '0));

  // R4
  event_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (count_o == CNT_W'(match_i)));

  // R6
  restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && (mode_q == TM_RESTART)) |=> (count_o == '0));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && (mode_q == TM_ONESHOT)) |=> (halted && $stable(count_o)));

  // R10
  mask_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !irq_en_i && !irq_clr_i) |=> flag);

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [27:0] match;
  logic        clr, en, wclr;
  logic        irq;
  logic [31:0] count;

  logic [1:0]  n_mode;
  logic [7:0]  n_match;
  logic        n_clr, n_en, n_wclr;
  logic        n_irq;
  logic [11:0] n_count;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .match_i(match),
    .cnt_clr_i(clr), .irq_en_i(en), .irq_clr_i(wclr),
    .irq_o(irq), .count_o(count)
  );

  tick_timer #(.CNT_W(12), .MATCH_W(8)) u_tick_timer_w (
    .clk(clk), .rst_n(rst_n), .mode_i(n_mode), .match_i(n_match),
    .cnt_clr_i(n_clr), .irq_en_i(n_en), .irq_clr_i(n_wclr),
    .irq_o(n_irq), .count_o(n_count)
  );

  // Behavioural model of the requirements
  logic [31:0] m_cnt;
  logic [1:0]  m_mode;
  logic        m_stop, m_flag;

  always @(posedge clk) begin : ref_model
    logic ev;
    ev = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_mode = 2'd0; m_stop = 1'b0; m_flag = 1'b0;
    end else begin
      if (mode != m_mode) begin            // R3
        m_mode = mode; m_cnt = 0; m_stop = 1'b0;
      end else if (clr) begin              // R8
        m_cnt = 0; m_stop = 1'b0;
      end else begin
        case (m_mode)
          2'd0: m_cnt = 0;                 // R2
          2'd1: if (!m_stop) begin         // R5
                  if (m_cnt == {4'b0, match}) begin ev = 1'b1; m_stop = 1'b1; end
                  else m_cnt = m_cnt + 1;
                end
          2'd2: if (m_cnt == {4'b0, match}) begin ev = 1'b1; m_cnt = 0; end  // R6
                else m_cnt = m_cnt + 1;
          default: begin                   // R7
                  if (m_cnt == {4'b0, match}) ev = 1'b1;
                  m_cnt = m_cnt + 1;
                end
        endcase
      end
      if (ev) m_flag = 1'b1;               // R9
      else if (wclr) m_flag = 1'b0;
    end
  end

  function automatic string tag_of(input logic [1:0] md);
    case (md)
      2'd0:    return "R2";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance n edges, comparing against the model 1 ns after each
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk(tag_of(m_mode), count, m_cnt);
      chk("R10", {31'b0, irq}, {31'b0, m_flag & en});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode = 0; match = 0; clr = 0; en = 0; wclr = 0;
    n_mode = 0; n_match = 0; n_clr = 0; n_en = 0; n_wclr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", count, 0);
    chk("R1", {31'b0, irq}, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", count, 0);

    // Single-shot, match 5
    mode = 2'd1; match = 28'd5; en = 1'b1;
    step(1);  chk("R3", count, 0);
    step(5);  chk("R5", count, 5);
    step(1);  chk("R4", {31'b0, irq}, 1); chk("R5", count, 5);
    step(5);  chk("R5", count, 5);
    wclr = 1'b1; step(1); wclr = 1'b0;
    step(4);  chk("R5", {31'b0, irq}, 0); chk("R5", count, 5);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R8", count, 0);
    step(6);  chk("R8", {31'b0, irq}, 1);

    // Restartable, match 3
    wclr = 1'b1; mode = 2'd2; match = 28'd3; step(1); wclr = 1'b0;
    chk("R3", count, 0);
    step(3);  chk("R6", count, 3);
    step(1);  chk("R6", count, 0); chk("R6", {31'b0, irq}, 1);
    step(4);  chk("R6", count, 0);

    // Match 0 with a held clear strobe: set wins
    match = 28'd0; wclr = 1'b1;
    step(3);  chk("R9", {31'b0, irq}, 1); chk("R6", count, 0);
    wclr = 1'b0;

    // Masking
    en = 1'b0; step(1); chk("R10", {31'b0, irq}, 0);
    en = 1'b1; #1;      chk("R10", {31'b0, irq}, 1);

    // Off mode
    mode = 2'd0; wclr = 1'b1; step(1); wclr = 1'b0;
    step(5);  chk("R2", count, 0); chk("R2", {31'b0, irq}, 0);

    // Continuous, match 10
    mode = 2'd3; match = 28'd10; step(20);
    chk("R7", count, 19);

    // Random mix checked against the model
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 63) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) match = 28'($urandom_range(0, 24));
      clr  = ($urandom_range(0, 39) == 0);
      wclr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) en = ~en;
      step(1);
    end
    clr = 1'b0; wclr = 1'b0;

    // Narrow instance: continuous wrap at 2^12
    n_mode = 2'd3; n_match = 8'd5; n_en = 1'b1;
    @(posedge clk); #1;
    chk("R3", {20'b0, n_count}, 0);
    repeat (4100) @(posedge clk);
    #1;
    chk("R7", {20'b0, n_count}, 4);
    chk("R7", {31'b0, n_irq}, 1);
    n_wclr = 1'b1; @(posedge clk); #1; n_wclr = 1'b0;
    chk("R9", {31'b0, n_irq}, 0);
    chk("R7", {20'b0, n_count}, 5);
    @(posedge clk); #1;
    chk("R7", {31'b0, n_irq}, 1);
    chk("R7", {20'b0, n_count}, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule